// File: doc/BRIEF.md
# Packet Report Serial Port

This block turns each packet the repeater forwards into a short serial report for a monitoring agent. Packet bytes arrive one per cycle on a strobed byte stream, with start and end markers, a flag saying the destination is local, the receiving port number and a statistics word. The block keeps the header of the packet (destination, source and type/length), skips the payload, and appends a tag byte and the statistics bytes. When the destination is local or is the all-ones broadcast address, no payload byte is skipped: the whole packet goes out, still followed by the tag and statistics.

Reports are shifted out on one data line with a free-running report clock and a drive-valid line. A small byte queue decouples the byte stream from the serial line. While a report is open, from its accepted start marker until its last statistics bit has been shifted, a new packet is not queued; it is left out of reporting. The current report then runs to completion before drive-valid falls.

Top module: `prr_report_port`

## Requirements
- R1: While reset is asserted, the report clock, report data and drive-valid outputs are all low.
- R2: The report clock is free running with a period of 2*HALF_DIV system clock cycles and equal high and low phases (default 20 cycles, 10 MHz from 200 MHz).
- R3: Report data and drive-valid change only on the system clock edge at which the report clock falls, so they are stable across every rising edge of the report clock.
- R4: Each reported byte is shifted least significant bit first, one bit per report clock period, and reported bytes keep the order in which they were queued; no queued byte is lost.
- R5: For a packet whose destination is neither local nor broadcast, the report holds the first HDR_BYTES (14) bytes of the packet, then the tag, then the statistics bytes.
- R6: When the destination-local flag is high on the start-marker beat, every byte of the packet is reported, followed by the tag and statistics bytes.
- R7: When the first DA_BYTES (6) bytes of the packet are all 8'hFF, every byte of the packet is reported, followed by the tag and statistics bytes.
- R8: The tag byte carries the receiving port number (sampled on the end-marker beat) in bits [PORT_W-1:0], a 1 in bit 7 when the whole packet was reported and 0 otherwise, and zeros elsewhere; it is followed by the statistics word (sampled on the end-marker beat), least significant byte first.
- R9: Drive-valid is high during every bit period in which a reported bit is on the data line and low once a report has finished.
- R10: A packet whose start marker arrives while a report is still open produces no reported bytes, and the open report's drive-valid stays high until its last statistics bit has been shifted.
- R11: A destination with any of its first six bytes different from 8'hFF and no local flag is treated as non-broadcast and compressed.
- R12: A packet shorter than HDR_BYTES is reported in full, followed by the tag (bit 7 clear) and the statistics bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte strobe for in_data |
| in_sop | input | 1 | Marks the first byte of a packet |
| in_eop | input | 1 | Marks the last byte of a packet |
| in_data | input | 8 | Packet byte |
| dst_local | input | 1 | Destination is local; sampled with the start marker |
| port_id | input | PORT_W | Receiving port; sampled with the end marker |
| stat_word | input | STAT_W | Packet statistics; sampled with the end marker |
| rpt_clk | output | 1 | Free-running report clock |
| rpt_dat | output | 1 | Serial report data |
| rpt_drv | output | 1 | High while a report bit is being driven |

## Verification
The bench rebuilds bytes from the serial line and compares them with a queue of expected bytes, so a design that shifted most significant bit first, skipped the header boundary by one byte or put the statistics bytes in the wrong order shows up as a byte mismatch. The broadcast decision is probed with an all-ones destination and with one whose sixth byte differs; a design that decided on fewer bytes, or on any one of them, would forward the near-broadcast payload. A second packet is started while the first report's trailer is still on the line; a design that queued it, or cut the first trailer short, would produce extra or missing bytes. A packet shorter than the header checks that the trailer follows immediately and that its full flag stays clear.

// File: rtl/prr_pkg.sv
package prr_pkg;

  typedef enum logic [1:0] {
    CAP_IDLE  = 2'd0,
    CAP_BODY  = 2'd1,
    CAP_TRAIL = 2'd2
  } cap_state_t;

  // one queued report byte, flagged when it closes the report
  typedef struct packed {
    logic       last;
    logic [7:0] data;
  } rpt_byte_t;

endpackage

// File: rtl/prr_clkgen.sv
module prr_clkgen #(
  parameter int HALF_DIV = 10
) (
  input  logic clk,
  input  logic rst_n,
  output logic rpt_clk,
  output logic tick_fall
);

  localparam int CW = $clog2(HALF_DIV + 1);
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          rclk_q, rclk_d;
  logic          wrap;

  always_comb begin
    wrap      = (cnt_q == LAST);
    cnt_d     = wrap ? '0 : cnt_q + 1'b1;
    rclk_d    = wrap ? ~rclk_q : rclk_q;
    tick_fall = wrap & rclk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      rclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      rclk_q <= rclk_d;
    end
  end

  assign rpt_clk = rclk_q;

endmodule

// File: rtl/prr_fifo.sv
module prr_fifo #(
  parameter int W     = 9,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  output logic         empty,
  output logic         full
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] PTR_LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_wr, do_rd;

  always_comb begin
    empty  = (cnt_q == '0);
    full   = (cnt_q == CNT_FULL);
    do_wr  = wr_en & ~full;
    do_rd  = rd_en & ~empty;
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    if (do_wr) wptr_d = (wptr_q == PTR_LAST) ? '0 : wptr_q + 1'b1;
    if (do_rd) rptr_d = (rptr_q == PTR_LAST) ? '0 : rptr_q + 1'b1;
    cnt_d = cnt_q;
    if (do_wr && !do_rd) cnt_d = cnt_q + 1'b1;
    if (!do_wr && do_rd) cnt_d = cnt_q - 1'b1;
    rd_data = mem[rptr_q];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  // storage carries no reset
  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr_q] <= wr_data;
  end

endmodule

// File: rtl/prr_capture.sv
module prr_capture
  import prr_pkg::*;
#(
  parameter int HDR_BYTES = 14,
  parameter int DA_BYTES  = 6,
  parameter int PORT_W    = 4,
  parameter int STAT_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  input  logic              dst_local,
  input  logic [PORT_W-1:0] port_id,
  input  logic [STAT_W-1:0] stat_word,
  input  logic              rpt_done,
  output logic              wr_en,
  output rpt_byte_t         wr_byte,
  output logic              rpt_open
);

  localparam int STAT_BYTES = STAT_W / 8;
  localparam int IDX_W      = $clog2(HDR_BYTES + 1);
  localparam int TR_W       = $clog2(STAT_BYTES + 1);
  localparam logic [IDX_W-1:0] HDR_L  = IDX_W'(HDR_BYTES);
  localparam logic [IDX_W-1:0] DA_L   = IDX_W'(DA_BYTES);
  localparam logic [TR_W-1:0]  TR_END = TR_W'(STAT_BYTES);

  cap_state_t        state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              local_q, local_d;
  logic              bcast_q, bcast_d;
  logic              full_q, full_d;
  logic [PORT_W-1:0] port_q, port_d;
  logic [STAT_W-1:0] stat_q, stat_d;
  logic [TR_W-1:0]   tcnt_q, tcnt_d;
  logic              open_q, open_d;

  logic       whole_now;
  logic       bcast_nx;
  logic [7:0] tag_byte;

  always_comb begin
    tag_byte                = '0;
    tag_byte[PORT_W-1:0]    = port_q;
    tag_byte[7]             = full_q;
  end

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    local_d = local_q;
    bcast_d = bcast_q;
    full_d  = full_q;
    port_d  = port_q;
    stat_d  = stat_q;
    tcnt_d  = tcnt_q;
    open_d  = open_q;
    wr_en   = 1'b0;
    wr_byte = '0;

    // payload is kept when local, or once the whole destination read all ones
    whole_now = local_q | ((idx_q >= DA_L) & bcast_q);
    bcast_nx  = (idx_q < DA_L) ? (bcast_q & (in_data == 8'hFF)) : bcast_q;

    if (rpt_done) open_d = 1'b0;

    unique case (state_q)
      CAP_IDLE: begin
        if (in_valid && in_sop && !open_q) begin
          open_d       = 1'b1;
          idx_d        = IDX_W'(1);
          local_d      = dst_local;
          bcast_d      = (in_data == 8'hFF);
          wr_en        = 1'b1;
          wr_byte.data = in_data;
          if (in_eop) begin
            full_d  = dst_local;
            port_d  = port_id;
            stat_d  = stat_word;
            tcnt_d  = '0;
            state_d = CAP_TRAIL;
          end else begin
            state_d = CAP_BODY;
          end
        end
      end

      CAP_BODY: begin
        if (in_valid) begin
          wr_en        = (idx_q < HDR_L) | whole_now;
          wr_byte.data = in_data;
          bcast_d      = bcast_nx;
          if (idx_q < HDR_L) idx_d = idx_q + 1'b1;
          if (in_eop) begin
            full_d  = local_q | (bcast_nx & (idx_q >= DA_L - IDX_W'(1)));
            port_d  = port_id;
            stat_d  = stat_word;
            tcnt_d  = '0;
            state_d = CAP_TRAIL;
          end
        end
      end

      CAP_TRAIL: begin
        wr_en = 1'b1;
        if (tcnt_q == '0) begin
          wr_byte.data = tag_byte;
        end else begin
          wr_byte.data = stat_q[7:0];
          stat_d       = stat_q >> 8;
        end
        wr_byte.last = (tcnt_q == TR_END);
        tcnt_d       = tcnt_q + 1'b1;
        if (tcnt_q == TR_END) state_d = CAP_IDLE;
      end

      default: state_d = CAP_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CAP_IDLE;
      idx_q   <= '0;
      local_q <= 1'b0;
      bcast_q <= 1'b0;
      full_q  <= 1'b0;
      port_q  <= '0;
      stat_q  <= '0;
      tcnt_q  <= '0;
      open_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      local_q <= local_d;
      bcast_q <= bcast_d;
      full_q  <= full_d;
      port_q  <= port_d;
      stat_q  <= stat_d;
      tcnt_q  <= tcnt_d;
      open_q  <= open_d;
    end
  end

  assign rpt_open = open_q;

endmodule

// File: rtl/prr_shifter.sv
module prr_shifter
  import prr_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      fifo_empty,
  input  rpt_byte_t fifo_byte,
  output logic      fifo_rd,
  output logic      ser_dat,
  output logic      ser_drv,
  output logic      rpt_done
);

  logic [7:0] sh_q, sh_d;
  logic [2:0] bcnt_q, bcnt_d;
  logic       act_q, act_d;
  logic       last_q, last_d;

  always_comb begin
    sh_d     = sh_q;
    bcnt_d   = bcnt_q;
    act_d    = act_q;
    last_d   = last_q;
    fifo_rd  = 1'b0;
    rpt_done = 1'b0;
    if (tick) begin
      if (act_q && (bcnt_q != 3'd0)) begin
        sh_d   = sh_q >> 1;
        bcnt_d = bcnt_q - 3'd1;
      end else begin
        rpt_done = act_q & last_q;
        if (!fifo_empty) begin
          fifo_rd = 1'b1;
          sh_d    = fifo_byte.data;
          bcnt_d  = 3'd7;
          act_d   = 1'b1;
          last_d  = fifo_byte.last;
        end else begin
          sh_d   = '0;
          act_d  = 1'b0;
          last_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      bcnt_q <= '0;
      act_q  <= 1'b0;
      last_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      bcnt_q <= bcnt_d;
      act_q  <= act_d;
      last_q <= last_d;
    end
  end

  assign ser_dat = act_q & sh_q[0];
  assign ser_drv = act_q;

endmodule

// File: rtl/prr_report_port.sv
module prr_report_port
  import prr_pkg::*;
#(
  parameter int HALF_DIV   = 10,
  parameter int HDR_BYTES  = 14,
  parameter int DA_BYTES   = 6,
  parameter int PORT_W     = 4,
  parameter int STAT_W     = 16,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_sop,
  input  logic              in_eop,
  input  logic [7:0]        in_data,
  input  logic              dst_local,
  input  logic [PORT_W-1:0] port_id,
  input  logic [STAT_W-1:0] stat_word,
  output logic              rpt_clk,
  output logic              rpt_dat,
  output logic              rpt_drv
);

  localparam int BW = $bits(rpt_byte_t);

  logic      tick_fall;
  logic      fifo_wr, fifo_rd, fifo_empty, fifo_full;
  rpt_byte_t wr_byte, rd_byte;
  logic      rpt_done, rpt_open;

  prr_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
    .clk       (clk),
    .rst_n     (rst_n),
    .rpt_clk   (rpt_clk),
    .tick_fall (tick_fall)
  );

  prr_capture #(
    .HDR_BYTES (HDR_BYTES),
    .DA_BYTES  (DA_BYTES),
    .PORT_W    (PORT_W),
    .STAT_W    (STAT_W)
  ) u_capture (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_data   (in_data),
    .dst_local (dst_local),
    .port_id   (port_id),
    .stat_word (stat_word),
    .rpt_done  (rpt_done),
    .wr_en     (fifo_wr),
    .wr_byte   (wr_byte),
    .rpt_open  (rpt_open)
  );

  prr_fifo #(.W(BW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (fifo_wr),
    .wr_data (wr_byte),
    .rd_en   (fifo_rd),
    .rd_data (rd_byte),
    .empty   (fifo_empty),
    .full    (fifo_full)
  );

  prr_shifter u_shifter (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick_fall),
    .fifo_empty (fifo_empty),
    .fifo_byte  (rd_byte),
    .fifo_rd    (fifo_rd),
    .ser_dat    (rpt_dat),
    .ser_drv    (rpt_drv),
    .rpt_done   (rpt_done)
  );

endmodule

// File: rtl/prr_report_checker.sv
module prr_report_checker #(
  parameter int HALF_DIV = 10
) (
  input logic clk,
  input logic rst_n,
  input logic rpt_clk,
  input logic rpt_dat,
  input logic rpt_drv,
  input logic rpt_open,
  input logic fifo_wr,
  input logic fifo_full
);

  localparam int HC_W = $clog2(HALF_DIV + 1) + 1;

  logic [HC_W-1:0] hcnt_q;
  logic            rclk_q;
  logic            seen_q;

  // cycles since the report clock last changed, as seen one edge later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q <= '0;
      rclk_q <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      rclk_q <= rpt_clk;
      if (rpt_clk != rclk_q) begin
        hcnt_q <= '0;
        seen_q <= 1'b1;
      end else if (hcnt_q != {HC_W{1'b1}}) begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  assert_clk_half_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rpt_clk != rclk_q) && seen_q) |-> (hcnt_q == HC_W'(HALF_DIV - 1)));

  assert_dat_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rpt_dat) || !$stable(rpt_drv)) |-> $fell(rpt_clk));

  assert_drv_in_report_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rpt_drv |-> rpt_open);

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> !fifo_full);

endmodule

bind prr_report_port prr_report_checker #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rpt_clk   (rpt_clk),
  .rpt_dat   (rpt_dat),
  .rpt_drv   (rpt_drv),
  .rpt_open  (rpt_open),
  .fifo_wr   (fifo_wr),
  .fifo_full (fifo_full)
);

// File: tb/prr_report_port_bench.sv
`timescale 1ns/1ps
module prr_report_port_bench;

  localparam int HALF_DIV  = 10;
  localparam int HDR_BYTES = 14;
  localparam int GAP       = 16 * HALF_DIV;

  logic        clk;
  logic        rst_n;
  logic        in_valid, in_sop, in_eop, dst_local;
  logic [7:0]  in_data;
  logic [3:0]  port_id;
  logic [15:0] stat_word;
  logic        rpt_clk, rpt_dat, rpt_drv;

  int checks   = 0;
  int failures = 0;
  int r3_viol  = 0;
  bit finished = 0;

  logic [7:0] exp_q[$];
  string      req_q[$];

  prr_report_port u_prr_report_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_sop    (in_sop),
    .in_eop    (in_eop),
    .in_data   (in_data),
    .dst_local (dst_local),
    .port_id   (port_id),
    .stat_word (stat_word),
    .rpt_clk   (rpt_clk),
    .rpt_dat   (rpt_dat),
    .rpt_drv   (rpt_drv)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // monitor: rebuild bytes LSB first and pop the scoreboard
  initial begin
    logic [7:0] cur;
    int nb;
    nb = 0;
    cur = '0;
    forever begin
      @(posedge rpt_clk);
      if (rst_n && rpt_drv) begin
        cur[nb] = rpt_dat;
        nb++;
        if (nb == 8) begin
          nb = 0;
          if (exp_q.size() == 0) begin
            check(1'b0, "R10", "unexpected byte", int'(cur), 0);
          end else begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(cur == e, r, "report byte", int'(cur), int'(e));
          end
        end
      end
    end
  end

  // R3: data may only move together with a falling report clock
  initial begin
    logic pd, pc;
    @(posedge rst_n);
    @(negedge clk);
    pd = rpt_dat;
    pc = rpt_clk;
    forever begin
      @(negedge clk);
      if ((rpt_dat != pd) && !(pc && !rpt_clk)) r3_viol++;
      pd = rpt_dat;
      pc = rpt_clk;
    end
  end

  task automatic build_pkt(input logic [47:0] da, input int len,
                           input logic [7:0] seed, output logic [7:0] q[$]);
    q = {};
    for (int i = 0; i < len; i++) begin
      if (i < 6) q.push_back(da[47 - 8*i -: 8]);
      else       q.push_back(8'(seed + 8'(i * 7)));
    end
  endtask

  task automatic send_pkt(input logic [7:0] pkt[$], input logic loc,
                          input logic [3:0] port, input logic [15:0] st,
                          input bit drop, input string req);
    bit whole;
    whole = loc;
    if (pkt.size() >= 6) begin
      bit allff;
      allff = 1;
      for (int i = 0; i < 6; i++) if (pkt[i] != 8'hFF) allff = 0;
      whole = whole | allff;
    end
    if (!drop) begin
      for (int i = 0; i < pkt.size(); i++) begin
        if (i < HDR_BYTES || whole) begin
          exp_q.push_back(pkt[i]);
          req_q.push_back(req);
        end
      end
      exp_q.push_back({whole, 3'b000, port});
      req_q.push_back("R8");
      exp_q.push_back(st[7:0]);
      req_q.push_back("R8");
      exp_q.push_back(st[15:8]);
      req_q.push_back("R8");
    end
    for (int i = 0; i < pkt.size(); i++) begin
      @(negedge clk);
      in_valid  = 1'b1;
      in_data   = pkt[i];
      in_sop    = (i == 0);
      in_eop    = (i == pkt.size() - 1);
      dst_local = loc;
      port_id   = port;
      stat_word = st;
      @(negedge clk);
      in_valid = 1'b0;
      in_sop   = 1'b0;
      in_eop   = 1'b0;
      repeat (GAP - 2) @(negedge clk);
    end
  endtask

  task automatic wait_drain(input string req);
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 60000) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, req, "bytes still pending", exp_q.size(), 0);
    repeat (3 * GAP) @(negedge clk);
    check(rpt_drv == 1'b0, "R9", "drive-valid after report", int'(rpt_drv), 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL R9 watchdog expired actual=running expected=idle");
    finish_run();
  end

  initial begin
    logic [7:0] p[$];
    realtime t0, t1, t2;
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_sop    = 1'b0;
    in_eop    = 1'b0;
    in_data   = '0;
    dst_local = 1'b0;
    port_id   = '0;
    stat_word = '0;
    repeat (6) @(negedge clk);
    check(rpt_clk == 1'b0, "R1", "report clock in reset", int'(rpt_clk), 0);
    check(rpt_dat == 1'b0, "R1", "report data in reset", int'(rpt_dat), 0);
    check(rpt_drv == 1'b0, "R1", "drive-valid in reset", int'(rpt_drv), 0);
    rst_n = 1'b1;

    // R2: period and duty of the report clock
    @(posedge rpt_clk); t0 = $realtime;
    @(negedge rpt_clk); t1 = $realtime;
    @(posedge rpt_clk); t2 = $realtime;
    check((t2 - t0) == 100.0, "R2", "period ns", int'(t2 - t0), 100);
    check((t1 - t0) == 50.0, "R2", "high time ns", int'(t1 - t0), 50);

    // R5 compressed unicast, port 3
    build_pkt(48'h0012_3456_789A, 20, 8'h10, p);
    send_pkt(p, 1'b0, 4'd3, 16'hA55A, 0, "R5");
    wait_drain("R5");

    // R6 local destination: whole packet
    build_pkt(48'h0200_0000_0001, 20, 8'h40, p);
    send_pkt(p, 1'b1, 4'd5, 16'h1234, 0, "R6");
    wait_drain("R6");

    // R7 broadcast destination: whole packet
    build_pkt(48'hFFFF_FFFF_FFFF, 18, 8'h80, p);
    send_pkt(p, 1'b0, 4'd9, 16'hBEEF, 0, "R7");
    wait_drain("R7");

    // R11 last destination byte differs from all ones
    build_pkt(48'hFFFF_FFFF_FFFE, 18, 8'hC0, p);
    send_pkt(p, 1'b0, 4'd12, 16'h0F0F, 0, "R11");
    wait_drain("R11");

    // R12 packet shorter than the header
    build_pkt(48'h0A0B_0C0D_0E0F, 8, 8'h22, p);
    send_pkt(p, 1'b0, 4'd15, 16'h8001, 0, "R12");
    wait_drain("R12");

    // R10 second packet starts while the first trailer is on the line
    build_pkt(48'h0011_2233_4455, 16, 8'h33, p);
    send_pkt(p, 1'b0, 4'd1, 16'h5AA5, 0, "R10");
    repeat (60) @(negedge clk);
    check(rpt_drv == 1'b1, "R10", "drive-valid while trailer open", int'(rpt_drv), 1);
    build_pkt(48'h0200_0000_0002, 16, 8'h55, p);
    send_pkt(p, 1'b1, 4'd2, 16'h7777, 1, "R10");
    wait_drain("R10");

    // R4 next accepted packet after the dropped one reports normally
    build_pkt(48'h00AA_BBCC_DDEE, 15, 8'h66, p);
    send_pkt(p, 1'b0, 4'd7, 16'hC33C, 0, "R4");
    wait_drain("R4");

    check(r3_viol == 0, "R3", "data changes off falling edge", r3_viol, 0);
    finish_run();
  end

endmodule